// File: doc/BRIEF.md
# Four-Group Severity Interrupt Aggregator

This block collects 128 interrupt event inputs into four groups of 32 sticky cause bits. Each group has a general mask and four severity masks: error, abort, fatal and log. For every severity class the block ORs the cause bits that neither the general mask nor that class's own mask suppresses. It drives the four class lines out as registered outputs, together with one registered summary line that is the OR of all four.

Software reaches the registers through a plain 32-bit port with a write strobe and a combinational read. A handler reads a group's cause register, services the events and clears them by writing ones to the bits. It tunes which classes report an event by setting bits in the per-class masks.

A parameter lists input positions that can never be masked. These positions drive all four class lines whatever the masks hold. A second parameter chooses whether the abort-class mask can be written or is fixed at zero.

Top module: `sev_irq_agg`

## Requirements
- R1: Register byte address = group*0x40 + offset, with the group taken from address bits [7:6] and the offset from bits [5:0]. Offsets: cause 0x00, general mask 0x10, error mask 0x2C, abort mask 0x30, fatal mask 0x34, log mask 0x38. Input g*32+b maps to cause bit b of group g.
- R2: A cause bit sets when its input is high in a cycle after being low in the previous cycle. An input held high does not set the bit again after it is cleared.
- R3: Writing 1 to a cause bit clears it, and writing 0 leaves it unchanged. When a rising input and a clear hit the same bit in the same cycle, the bit stays set.
- R4: After reset the cause registers read 0, the general masks read 0xFFFFFFFF, the four severity masks read 0, and sev_line_o and summary_o are 0.
- R5: sev_line_o bit s (0 error, 1 abort, 2 fatal, 3 log) is 1 when some group has a cause bit set whose general mask bit and class-s mask bit are both 0.
- R6: sev_line_o and summary_o are registered. They change on the clock edge after the cause or mask edge that produces the change, and they return to 0 once every contributing cause bit is cleared or masked. summary_o is the OR of the four class lines.
- R7: A cause bit whose general mask bit is 1 drives no class line.
- R8: A cause bit at a position marked in UNMASKABLE drives all four class lines, whatever its general mask and class mask bits hold.
- R9: With ABORT_MASK_WR=1 the abort mask is read/write. With ABORT_MASK_WR=0 it reads 0 and writes to it are ignored.
- R10: Reads of any other offset return 0, and writes to any other offset change no register.
- R11: The class lines are independent: setting a bit in one class mask does not affect the other three lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 128 | Event inputs, index g*32+b |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| sev_line_o | output | 4 | Registered class lines: error, abort, fatal, log |
| summary_o | output | 1 | Registered OR of the class lines |

## Verification
The bench drives a rising input and a write-one clear into the same bit in the same cycle; a design that gave the clear priority would lose that event. It holds an input high across a clear, which catches a design that latches levels instead of edges. It measures the exact cycle at which the summary appears and checks that it drops after the last contributing bit is cleared. It also checks that an unmaskable position fires all four classes while fully masked, that writes to unused offsets are discarded, and that a read-only abort mask stays zero. Random traffic then mixes pulses, mask writes and clears against a bit-by-bit model.

// File: rtl/sev_irq_pkg.sv
package sev_irq_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned N_SEV = 4;
  localparam int unsigned OFS_W = 6;

  typedef enum logic [1:0] {
    SEV_ERR   = 2'd0,
    SEV_ABORT = 2'd1,
    SEV_FATAL = 2'd2,
    SEV_LOG   = 2'd3
  } sev_e;

  localparam logic [OFS_W-1:0] OFS_CAUSE = 6'h00;
  localparam logic [OFS_W-1:0] OFS_GMASK = 6'h10;
  localparam logic [OFS_W-1:0] OFS_ERR   = 6'h2C;
  localparam logic [OFS_W-1:0] OFS_ABORT = 6'h30;
  localparam logic [OFS_W-1:0] OFS_FATAL = 6'h34;
  localparam logic [OFS_W-1:0] OFS_LOG   = 6'h38;

  // Offset of the class-s mask register inside a group window
  function automatic logic [OFS_W-1:0] sev_ofs(input int unsigned s);
    case (s)
      0:       return OFS_ERR;
      1:       return OFS_ABORT;
      2:       return OFS_FATAL;
      default: return OFS_LOG;
    endcase
  endfunction

  function automatic logic ofs_is_mapped(input logic [OFS_W-1:0] o);
    return (o == OFS_CAUSE) || (o == OFS_GMASK) || (o == OFS_ERR) ||
           (o == OFS_ABORT) || (o == OFS_FATAL) || (o == OFS_LOG);
  endfunction

  // Sticky update: set wins over write-one-clear
  function automatic logic [REG_W-1:0] cause_next(input logic [REG_W-1:0] cur,
                                                  input logic [REG_W-1:0] clr,
                                                  input logic [REG_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  // One class line of one group
  function automatic logic sev_hit(input logic [REG_W-1:0] cause,
                                   input logic [REG_W-1:0] gmask,
                                   input logic [REG_W-1:0] smask,
                                   input logic [REG_W-1:0] unm);
    return |(cause & ((~gmask & ~smask) | unm));
  endfunction
endpackage

// File: rtl/sev_grp_bank.sv
module sev_grp_bank
  import sev_irq_pkg::*;
#(
  parameter bit               ABORT_MASK_WR = 1'b1,
  parameter logic [REG_W-1:0] UNM           = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [REG_W-1:0]       rise_i,
  input  logic                   wr_en,
  input  logic [OFS_W-1:0]       ofs,
  input  logic [REG_W-1:0]       wdata,
  output logic [REG_W-1:0]       rdata,
  output logic [N_SEV-1:0]       lines_o,
  output logic [REG_W-1:0]       cause_o
);
  logic [REG_W-1:0]            cause_q;
  logic [REG_W-1:0]            gmask_q;
  logic [N_SEV-1:0][REG_W-1:0] smask_q;
  logic [REG_W-1:0]            clr_vec;
  logic                        gmask_wr;
  logic [N_SEV-1:0]            smask_wr;
  logic                        ofs_mapped;

  assign ofs_mapped = ofs_is_mapped(ofs);
  assign clr_vec    = (wr_en && ofs == OFS_CAUSE) ? wdata : '0;
  assign gmask_wr   = wr_en && (ofs == OFS_GMASK);

  always_comb begin
    for (int s = 0; s < N_SEV; s++) begin
      smask_wr[s] = wr_en && (ofs == sev_ofs(s)) &&
                    (ABORT_MASK_WR || (s != int'(SEV_ABORT)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      gmask_q <= '1;
      smask_q <= '0;
    end else begin
      cause_q <= cause_next(cause_q, clr_vec, rise_i);
      if (gmask_wr) gmask_q <= wdata;
      for (int s = 0; s < N_SEV; s++) begin
        if (smask_wr[s]) smask_q[s] <= wdata;
      end
    end
  end

  always_comb begin
    for (int s = 0; s < N_SEV; s++) begin
      lines_o[s] = sev_hit(cause_q, gmask_q, smask_q[s], UNM);
    end
  end

  always_comb begin
    case (ofs)
      OFS_CAUSE: rdata = cause_q;
      OFS_GMASK: rdata = gmask_q;
      OFS_ERR:   rdata = smask_q[SEV_ERR];
      OFS_ABORT: rdata = smask_q[SEV_ABORT];
      OFS_FATAL: rdata = smask_q[SEV_FATAL];
      OFS_LOG:   rdata = smask_q[SEV_LOG];
      default:   rdata = '0;
    endcase
  end

  assign cause_o = cause_q;

  // R3: a rising input is set on the next edge even under a clear
  a_r3_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_i) |=> ((cause_q & $past(rise_i)) == $past(rise_i)));

  // R2: set bits not being cleared stay set
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cause_q & ~clr_vec)) |=>
      ((cause_q & $past(cause_q & ~clr_vec)) == $past(cause_q & ~clr_vec)));

  // R10: writes to unused offsets leave masks untouched
  a_r10_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ofs_mapped) |=> ($stable(gmask_q) && $stable(smask_q)));

  if (!ABORT_MASK_WR) begin : g_abort_ro
    // R9: fixed abort mask never moves off zero
    a_r9_abort_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (smask_q[SEV_ABORT] == '0));
  end
endmodule

// File: rtl/sev_summary.sv
module sev_summary
  import sev_irq_pkg::*;
#(
  parameter int unsigned NUM_GRP = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_GRP*N_SEV-1:0]   lines_i,
  output logic [N_SEV-1:0]           sev_line_o,
  output logic                       summary_o
);
  logic [N_SEV-1:0] sev_any;

  always_comb begin
    sev_any = '0;
    for (int g = 0; g < int'(NUM_GRP); g++) begin
      for (int s = 0; s < N_SEV; s++) begin
        sev_any[s] = sev_any[s] | lines_i[g*N_SEV+s];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sev_line_o <= '0;
      summary_o  <= 1'b0;
    end else begin
      sev_line_o <= sev_any;
      summary_o  <= |sev_any;
    end
  end
endmodule

// File: rtl/sev_irq_agg.sv
module sev_irq_agg
  import sev_irq_pkg::*;
#(
  parameter int unsigned                NUM_GRP       = 4,
  parameter bit                         ABORT_MASK_WR = 1'b1,
  parameter logic [NUM_GRP*REG_W-1:0]   UNMASKABLE    = '0,
  localparam int unsigned               NUM_IN        = NUM_GRP * REG_W,
  localparam int unsigned               GSEL_W        = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int unsigned               ADDR_W        = GSEL_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] evt_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [N_SEV-1:0]  sev_line_o,
  output logic              summary_o
);
  logic [NUM_IN-1:0]        evt_q;
  logic [NUM_IN-1:0]        rise;
  logic [NUM_IN-1:0]        cause_all;
  logic [NUM_GRP*N_SEV-1:0] grp_lines;
  logic [REG_W-1:0]         bank_rd [NUM_GRP];
  logic [GSEL_W-1:0]        grp_sel;
  logic [OFS_W-1:0]         ofs;

  assign grp_sel = reg_addr[ADDR_W-1:OFS_W];
  assign ofs     = reg_addr[OFS_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_i;
  end
  assign rise = evt_i & ~evt_q;

  for (genvar g = 0; g < int'(NUM_GRP); g++) begin : g_bank
    logic bank_wr;
    assign bank_wr = reg_wr && (grp_sel == GSEL_W'(g));
    sev_grp_bank #(
      .ABORT_MASK_WR (ABORT_MASK_WR),
      .UNM           (UNMASKABLE[g*REG_W +: REG_W])
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise_i  (rise[g*REG_W +: REG_W]),
      .wr_en   (bank_wr),
      .ofs     (ofs),
      .wdata   (reg_wdata),
      .rdata   (bank_rd[g]),
      .lines_o (grp_lines[g*N_SEV +: N_SEV]),
      .cause_o (cause_all[g*REG_W +: REG_W])
    );
  end

  assign reg_rdata = (int'(grp_sel) < int'(NUM_GRP)) ? bank_rd[grp_sel] : '0;

  sev_summary #(.NUM_GRP(NUM_GRP)) u_sum (
    .clk        (clk),
    .rst_n      (rst_n),
    .lines_i    (grp_lines),
    .sev_line_o (sev_line_o),
    .summary_o  (summary_o)
  );

  // R6: no cause anywhere means the summary is low one edge later
  a_r6_quiet_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_all == '0) |=> !summary_o);

  // R6: a high summary needs a cause bit on the previous cycle
  a_r6_summary_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    summary_o |-> $past(|cause_all));

  // R8: an unmaskable cause drives every class line
  a_r8_unmaskable_all: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cause_all & UNMASKABLE)) |=> (sev_line_o == '1));
endmodule

// File: tb/sev_irq_agg_test.sv
`timescale 1ns/1ps
module sev_irq_agg_test;
  localparam logic [127:0] UNM_B = (128'd1 << 37) | (128'd1 << 100);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] evt = '0;
  logic [7:0]   reg_addr = '0;
  logic         reg_wr = 1'b0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  rdata, rdata_ro;
  logic [3:0]   lines, lines_ro;
  logic         summ, summ_ro;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [31:0] m_cause [4];
  logic [31:0] m_gm    [4];
  logic [31:0] m_sm    [4][4];

  always #2.5 clk = ~clk;

  sev_irq_agg #(.ABORT_MASK_WR(1'b1), .UNMASKABLE(UNM_B)) uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata), .sev_line_o(lines), .summary_o(summ));

  sev_irq_agg #(.ABORT_MASK_WR(1'b0), .UNMASKABLE(UNM_B)) uut_ro (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_ro), .sev_line_o(lines_ro), .summary_o(summ_ro));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bit-by-bit model of the class lines
  function automatic logic [3:0] exp_lines();
    logic [3:0] r = '0;
    for (int i = 0; i < 128; i++) begin
      for (int s = 0; s < 4; s++) begin
        if (m_cause[i/32][i%32] &&
            (UNM_B[i] || (!m_gm[i/32][i%32] && !m_sm[i/32][s][i%32])))
          r[s] = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    int g = a[7:6];
    case (a[5:0])
      6'h00: return m_cause[g];
      6'h10: return m_gm[g];
      6'h2C: return m_sm[g][0];
      6'h30: return m_sm[g][1];
      6'h34: return m_sm[g][2];
      6'h38: return m_sm[g][3];
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_wr(input logic [7:0] a, input logic [31:0] d);
    int g = a[7:6];
    case (a[5:0])
      6'h00: m_cause[g] = m_cause[g] & ~d;
      6'h10: m_gm[g] = d;
      6'h2C: m_sm[g][0] = d;
      6'h30: m_sm[g][1] = d;
      6'h34: m_sm[g][2] = d;
      6'h38: m_sm[g][3] = d;
      default: ;
    endcase
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic pulse(input logic [127:0] bits);
    @(negedge clk);
    evt = bits;
    @(negedge clk);
    evt = '0;
    for (int i = 0; i < 128; i++) if (bits[i]) m_cause[i/32][i%32] = 1'b1;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic line_chk(input string req);
    @(posedge clk);
    #1;
    chk({req, " lines"}, {28'b0, lines}, {28'b0, exp_lines()});
    chk({req, " summary"}, {31'b0, summ}, {31'b0, |exp_lines()});
  endtask

  initial begin
    #900000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int g = 0; g < 4; g++) begin
      m_cause[g] = '0; m_gm[g] = '1;
      for (int s = 0; s < 4; s++) m_sm[g][s] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R4 reset state
    for (int g = 0; g < 4; g++) begin
      rd_chk("R4 cause reset", 8'(g*64), 32'h0);
      rd_chk("R4 gmask reset", 8'(g*64 + 'h10), 32'hFFFF_FFFF);
      rd_chk("R4 log mask reset", 8'(g*64 + 'h38), 32'h0);
    end
    chk("R4 outputs reset", {27'b0, lines, summ}, 32'h0);

    // R1 / R7: input 70 lands in group 2 bit 6, masked by default
    pulse(128'd1 << 70);
    rd_chk("R1 cause mapping", 8'h80, 32'h0000_0040);
    line_chk("R7 general mask blocks");

    // R5: unmask group 2, all classes fire
    wr(8'h90, 32'h0);
    line_chk("R5 class lines");
    chk("R5 all four", {28'b0, lines}, 32'hF);

    // R3 write-one clear, R6 deassert
    wr(8'h80, 32'h0000_0001);
    rd_chk("R3 write zero keeps", 8'h80, 32'h40);
    wr(8'h80, 32'h0000_0040);
    rd_chk("R3 clear", 8'h80, 32'h0);
    line_chk("R6 deassert after clear");

    // R6 latency: cause at edge A, outputs at edge B
    @(negedge clk); evt[70] = 1'b1;
    @(posedge clk); #1;
    chk("R6 not before next edge", {31'b0, summ}, 32'h0);
    @(posedge clk); #1;
    chk("R6 one edge after cause", {31'b0, summ}, 32'h1);
    @(negedge clk); evt[70] = 1'b0;
    m_cause[2][6] = 1'b1;

    // R3 same-cycle event and clear: event wins
    wr(8'h80, 32'h40);
    @(negedge clk);
    evt[70] = 1'b1; reg_addr = 8'h80; reg_wdata = 32'h40; reg_wr = 1'b1;
    @(negedge clk);
    evt[70] = 1'b0; reg_wr = 1'b0;
    m_cause[2][6] = 1'b1;
    rd_chk("R3 event beats clear", 8'h80, 32'h40);

    // R11: error mask on that bit drops only the error line
    wr(8'hAC, 32'h40);
    line_chk("R11 independent classes");
    chk("R11 error only off", {28'b0, lines}, 32'hE);

    // R2: held level does not re-set after clear
    @(negedge clk); evt[5] = 1'b1;
    @(negedge clk); m_cause[0][5] = 1'b1;
    wr(8'h00, 32'h20);
    wr(8'h00, 32'h0);
    rd_chk("R2 level held no reset", 8'h00, 32'h0);
    @(negedge clk); evt[5] = 1'b0;
    rd_chk("R2 falling edge no set", 8'h00, 32'h0);

    // R9 abort mask writable vs fixed
    wr(8'h70, 32'hFFFF_FFFF);
    rd_chk("R9 abort writable", 8'h70, 32'hFFFF_FFFF);
    chk("R9 abort read-only", rdata_ro, 32'h0);

    // R10 unmapped offsets
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h14, 32'h1234_5678);
    rd_chk("R10 unmapped read", 8'h04, 32'h0);
    rd_chk("R10 unmapped read2", 8'h14, 32'h0);
    rd_chk("R10 gmask untouched", 8'h10, 32'hFFFF_FFFF);
    rd_chk("R10 cause untouched", 8'h00, 32'h0);

    // R8 unmaskable bit 37 with every mask of group 1 set
    wr(8'h90, 32'hFFFF_FFFF);
    for (int s = 0; s < 4; s++) wr(8'(64 + (s == 0 ? 'h2C : 'h30 + 4*(s-1))), 32'hFFFF_FFFF);
    wr(8'h80, 32'hFFFF_FFFF);
    line_chk("R8 quiet before");
    pulse(128'd1 << 37);
    line_chk("R8 unmaskable fires");
    chk("R8 all lines", {28'b0, lines}, 32'hF);
    wr(8'h40, 32'h20);
    line_chk("R8 cleared");

    // Random mix against the model
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 5);
      if (op <= 1) begin
        logic [127:0] b;
        for (int g = 0; g < 4; g++) b[g*32 +: 32] = $urandom & $urandom & $urandom;
        pulse(b);
      end else if (op == 2) begin
        wr(8'($urandom_range(0, 3) * 64), $urandom);
      end else begin
        logic [5:0] o;
        case ($urandom_range(0, 6))
          0: o = 6'h10; 1: o = 6'h2C; 2: o = 6'h30; 3: o = 6'h34;
          4: o = 6'h38; 5: o = 6'h18; default: o = 6'h10;
        endcase
        wr({2'($urandom_range(0, 3)), o}, ($urandom_range(0, 1) == 1) ? $urandom : 32'h0);
      end
      line_chk("R5 R6 random");
      begin
        logic [7:0] a = {2'($urandom_range(0, 3)),
                         ($urandom_range(0, 1) == 1) ? 6'h00 : 6'($urandom_range(0, 15) * 4)};
        rd_chk("R1 R10 random read", a, exp_read(a));
      end
    end
    reg_addr = 8'hF0;
    #1;
    chk("R9 abort read-only after random", rdata_ro, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule